// File: doc/BRIEF.md
# Scanline Replication Vertical Counter

This block lives in the vertical timing path of a display controller. It counts output scanlines once per horizontal line tick and works out which source scanline each output line shows. Output lines can map one to one, each source line can be shown twice (double scanning), or every fourth output line can repeat the line before it (three-of-four scanning). Graphics and text modes use separate code values for these patterns.

A 3-bit scan-function field selects the pattern, and a text-mode input says which family of codes is live. A separate 200-line enable forces double scanning whatever the field holds. A halving enable makes the counter wrap at half the programmed vertical total. Frame start clears the line counter and the replication phase.

The outputs are the 10-bit line count, the source row address and a repeat flag. The repeat flag marks an output line that shows the same source row as the line before it. All outputs are registered and change on the clock edge that samples a line tick or a frame start.

Top module: `scanrep_top`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `line_count`, `src_row` and `repeat_line` are all 0.
- R2: A cycle with `frame_start` high clears `line_count`, `src_row`, `repeat_line` and the replication phase on the next edge, and this takes priority over a `line_tick` in the same cycle.
- R3: Each `line_tick` raises `line_count` by one. A tick taken while `line_count` equals the wrap limit minus 1 returns `line_count` to 0 and restarts the replication pattern. With halving off, the wrap limit is `vtotal`.
- R4: With `vdiv2_en` high, the wrap limit is `vtotal` shifted right by one.
- R5: Scan-function code 0 gives normal scanning: `src_row` equals the line index since the last restart and `repeat_line` stays 0.
- R6: In graphics mode (`text_mode`=0), code 1 gives double scanning: output line k shows source row k/2, and `repeat_line` is 1 on odd k.
- R7: In graphics mode, code 2 gives three-of-four scanning: output line k shows source row 3*(k/4)+min(k mod 4, 2), and `repeat_line` is 1 when k mod 4 is 3.
- R8: In text mode (`text_mode`=1), code 5 gives the double pattern of R6 and code 6 gives the three-of-four pattern of R7.
- R9: Codes 5 and 6 act as normal scanning in graphics mode, codes 1 and 2 act as normal scanning in text mode, and codes 3, 4 and 7 act as normal scanning in both modes.
- R10: With `dbl200_en` high, the double pattern of R6 applies whatever the scan-function code and mode.
- R11: In cycles without `line_tick` or `frame_start`, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_tick | input | 1 | One-cycle pulse per horizontal line |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| scan_func | input | 3 | Scan-function code |
| text_mode | input | 1 | 1 = text mode, 0 = graphics mode |
| dbl200_en | input | 1 | Forces double scanning |
| vdiv2_en | input | 1 | Halves the vertical wrap limit |
| vtotal | input | 10 | Programmed vertical total (wrap limit) |
| line_count | output | 10 | Current output line count |
| src_row | output | 10 | Source row address for the current line |
| repeat_line | output | 1 | Current line repeats the previous source row |

## Verification
Each mode is run for more than one full replication group after a frame start, and every line is compared with a closed-form mapping from line index to source row. This separates the double pattern, the three-of-four pattern and normal scanning. Every code is also tried in the other mode and with codes 3, 4 and 7, which shows whether the decoder gates codes by mode. Short totals, with and without halving, show that the counter and the phase restart together at the wrap. A frame start in the same cycle as a tick, and idle stretches with no tick, cover priority and hold behaviour.

// File: rtl/scanrep_pkg.sv
// Shared types and code values for the scanline replication block.
package scanrep_pkg;

    // Replication pattern chosen by the mode decoder.
    typedef enum logic [1:0] {
        REP_NONE,
        REP_DOUBLE,
        REP_THREE_OF_FOUR
    } rep_kind_t;

    localparam int unsigned SCAN_FUNC_W = 3;

    localparam logic [SCAN_FUNC_W-1:0] CODE_GFX_DOUBLE = 3'd1;
    localparam logic [SCAN_FUNC_W-1:0] CODE_GFX_3OF4   = 3'd2;
    localparam logic [SCAN_FUNC_W-1:0] CODE_TXT_DOUBLE = 3'd5;
    localparam logic [SCAN_FUNC_W-1:0] CODE_TXT_3OF4   = 3'd6;

endpackage

// File: rtl/scanrep_mode_dec.sv
// Mode decoder: turns the scan-function code, the text/graphics select and
// the 200-line force bit into one replication pattern.
// Assumes: codes for the other mode family, and unused codes, mean normal.
module scanrep_mode_dec
    import scanrep_pkg::*;
(
    input  logic [SCAN_FUNC_W-1:0] scan_func,
    input  logic                   text_mode,
    input  logic                   dbl200_en,
    output rep_kind_t              kind
);

    // Pick the pattern; the force bit takes precedence over the field.
    always_comb begin
        kind = REP_NONE;
        if (dbl200_en) begin
            kind = REP_DOUBLE;
        end else if (text_mode) begin
            if (scan_func == CODE_TXT_DOUBLE)    kind = REP_DOUBLE;
            else if (scan_func == CODE_TXT_3OF4) kind = REP_THREE_OF_FOUR;
        end else begin
            if (scan_func == CODE_GFX_DOUBLE)    kind = REP_DOUBLE;
            else if (scan_func == CODE_GFX_3OF4) kind = REP_THREE_OF_FOUR;
        end
    end

endmodule

// File: rtl/scanrep_line_ctr.sv
// Vertical line counter: counts line ticks, clears on frame start and wraps
// at the vertical total (or half of it when halving is on).
// Assumes: frame_start outranks line_tick; a limit of 0 keeps the count at 0.
module scanrep_line_ctr #(
    parameter int unsigned LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_tick,
    input  logic              vdiv2_en,
    input  logic [LINE_W-1:0] vtotal,
    output logic [LINE_W-1:0] line_count,
    output logic              wrap
);

    localparam int unsigned CMP_W = LINE_W + 1;

    logic [LINE_W-1:0] limit;
    logic [CMP_W-1:0]  count_plus1;

    // Effective wrap limit and end-of-frame detect.
    always_comb begin
        limit       = vdiv2_en ? (vtotal >> 1) : vtotal;
        count_plus1 = {1'b0, line_count} + CMP_W'(1);
        wrap        = line_tick && (count_plus1 >= {1'b0, limit});
    end

    // Line count register.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start || wrap) begin
            line_count <= '0;
        end else if (line_tick) begin
            line_count <= line_count + LINE_W'(1);
        end
    end

    // R3/R4: after a tick the count lies below the limit in force at that tick.
    assert_wrap_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && !frame_start && limit != '0) |=> (line_count < $past(limit)));

    // R2: frame start clears the count.
    assert_frame_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (line_count == '0));

endmodule

// File: rtl/scanrep_seq.sv
// Replication sequencer: steps a phase per line and advances the source row
// except on repeated lines.
// Assumes: wrap comes from the line counter in the same cycle as the tick.
module scanrep_seq
    import scanrep_pkg::*;
#(
    parameter int unsigned LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_tick,
    input  logic              wrap,
    input  rep_kind_t         kind,
    output logic [LINE_W-1:0] src_row,
    output logic              repeat_line
);

    localparam int unsigned PHASE_W = 2;

    logic [PHASE_W-1:0] phase;
    logic [PHASE_W-1:0] phase_nxt;
    logic               advance;
    logic               rep_nxt;

    // Next phase, whether the source row moves, and the next repeat flag.
    always_comb begin
        case (kind)
            REP_DOUBLE: begin
                phase_nxt = {1'b0, ~phase[0]};
                advance   = (phase_nxt == '0);
                rep_nxt   = (phase_nxt == PHASE_W'(1));
            end
            REP_THREE_OF_FOUR: begin
                phase_nxt = phase + PHASE_W'(1);
                advance   = (phase_nxt != PHASE_W'(3));
                rep_nxt   = (phase_nxt == PHASE_W'(3));
            end
            default: begin
                phase_nxt = '0;
                advance   = 1'b1;
                rep_nxt   = 1'b0;
            end
        endcase
    end

    // Phase, source row and repeat flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start || wrap) begin
            phase       <= '0;
            src_row     <= '0;
            repeat_line <= 1'b0;
        end else if (line_tick) begin
            phase       <= phase_nxt;
            src_row     <= src_row + LINE_W'(advance);
            repeat_line <= rep_nxt;
        end
    end

    // R5: normal scanning never flags a repeat.
    assert_normal_no_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == REP_NONE && line_tick) |=> !repeat_line);

    // R6: in double scanning a repeated line is followed by a fresh one.
    assert_double_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == REP_DOUBLE && line_tick && repeat_line) |=> !repeat_line);

    // R7: in three-of-four scanning two repeats never come back to back.
    assert_three_of_four_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == REP_THREE_OF_FOUR && line_tick && repeat_line) |=> !repeat_line);

    // R11: without a tick or frame start the source row holds.
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_tick && !frame_start) |=> $stable(src_row) && $stable(repeat_line));

endmodule

// File: rtl/scanrep_top.sv
// Scanline replication vertical counter: line counter plus a source-row
// sequencer driven by the decoded scan pattern.
// Assumes: mode inputs change only between frames.
module scanrep_top
    import scanrep_pkg::*;
#(
    parameter int unsigned LINE_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   line_tick,
    input  logic                   frame_start,
    input  logic [SCAN_FUNC_W-1:0] scan_func,
    input  logic                   text_mode,
    input  logic                   dbl200_en,
    input  logic                   vdiv2_en,
    input  logic [LINE_W-1:0]      vtotal,
    output logic [LINE_W-1:0]      line_count,
    output logic [LINE_W-1:0]      src_row,
    output logic                   repeat_line
);

    rep_kind_t kind;
    logic      wrap;

    scanrep_mode_dec u_dec (
        .scan_func (scan_func),
        .text_mode (text_mode),
        .dbl200_en (dbl200_en),
        .kind      (kind)
    );

    scanrep_line_ctr #(.LINE_W(LINE_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_tick   (line_tick),
        .vdiv2_en    (vdiv2_en),
        .vtotal      (vtotal),
        .line_count  (line_count),
        .wrap        (wrap)
    );

    scanrep_seq #(.LINE_W(LINE_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_tick   (line_tick),
        .wrap        (wrap),
        .kind        (kind),
        .src_row     (src_row),
        .repeat_line (repeat_line)
    );

    // R3: the source row never runs ahead of the line count.
    assert_src_behind_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        src_row <= line_count);

    // R10: with the force bit, a repeated line is always followed by a fresh one.
    assert_forced_double_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl200_en && line_tick && !frame_start && repeat_line) |=> !repeat_line);

    // R2: frame start clears source row and repeat flag.
    assert_frame_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (src_row == '0 && !repeat_line));

endmodule

// File: tb/test_scanrep_top.sv
module test_scanrep_top;

    localparam int LW = 10;
    localparam int K_NONE = 0;
    localparam int K_DBL  = 1;
    localparam int K_34   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_tick = 1'b0;
    logic          frame_start = 1'b0;
    logic [2:0]    scan_func = 3'd0;
    logic          text_mode = 1'b0;
    logic          dbl200_en = 1'b0;
    logic          vdiv2_en = 1'b0;
    logic [LW-1:0] vtotal = 10'd100;
    logic [LW-1:0] line_count;
    logic [LW-1:0] src_row;
    logic          repeat_line;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    scanrep_top i_scanrep_top (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .frame_start(frame_start),
        .scan_func(scan_func), .text_mode(text_mode), .dbl200_en(dbl200_en),
        .vdiv2_en(vdiv2_en), .vtotal(vtotal), .line_count(line_count),
        .src_row(src_row), .repeat_line(repeat_line)
    );

    task automatic check(string req, int el, int es, bit er);
        checks++;
        if (line_count != el || src_row != es || repeat_line != er) begin
            fails++;
            $display("FAIL %s: got line=%0d src=%0d rep=%0d, expected line=%0d src=%0d rep=%0d",
                     req, line_count, src_row, repeat_line, el, es, er);
        end
    endtask

    function automatic int exp_src(int kind, int k);
        if (kind == K_DBL) return k / 2;
        if (kind == K_34)  return 3 * (k / 4) + ((k % 4) > 2 ? 2 : (k % 4));
        return k;
    endfunction

    function automatic bit exp_rep(int kind, int k);
        if (kind == K_DBL) return (k % 2) == 1;
        if (kind == K_34)  return (k % 4) == 3;
        return 1'b0;
    endfunction

    task automatic pulse_frame();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk) line_tick = 1'b1;
        @(negedge clk) line_tick = 1'b0;
    endtask

    // Start a frame and step n lines, checking each against the model.
    task automatic run_lines(string req, int kind, int n, int limit);
        pulse_frame();
        check(req, 0, 0, 1'b0);
        for (int i = 1; i <= n; i++) begin
            int k;
            tick();
            k = i % limit;
            check(req, k, exp_src(kind, k), exp_rep(kind, k));
        end
    endtask

    task automatic set_mode(bit txt, logic [2:0] code, bit f200);
        @(negedge clk);
        text_mode = txt; scan_func = code; dbl200_en = f200;
    endtask

    task automatic t_reset();
        @(negedge clk) check("R1", 0, 0, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk) check("R1", 0, 0, 1'b0);
    endtask

    task automatic t_normal();
        set_mode(1'b0, 3'd0, 1'b0);
        run_lines("R5", K_NONE, 9, 100);
    endtask

    task automatic t_gfx_patterns();
        set_mode(1'b0, 3'd1, 1'b0);
        run_lines("R6", K_DBL, 9, 100);
        set_mode(1'b0, 3'd2, 1'b0);
        run_lines("R7", K_34, 13, 100);
    endtask

    task automatic t_text_patterns();
        set_mode(1'b1, 3'd5, 1'b0);
        run_lines("R8", K_DBL, 9, 100);
        set_mode(1'b1, 3'd6, 1'b0);
        run_lines("R8", K_34, 13, 100);
    endtask

    task automatic t_cross_codes();
        set_mode(1'b0, 3'd5, 1'b0); run_lines("R9", K_NONE, 5, 100);
        set_mode(1'b0, 3'd6, 1'b0); run_lines("R9", K_NONE, 5, 100);
        set_mode(1'b1, 3'd1, 1'b0); run_lines("R9", K_NONE, 5, 100);
        set_mode(1'b1, 3'd2, 1'b0); run_lines("R9", K_NONE, 5, 100);
        for (int t = 0; t < 2; t++) begin
            set_mode(t[0], 3'd3, 1'b0); run_lines("R9", K_NONE, 5, 100);
            set_mode(t[0], 3'd4, 1'b0); run_lines("R9", K_NONE, 5, 100);
            set_mode(t[0], 3'd7, 1'b0); run_lines("R9", K_NONE, 5, 100);
        end
    endtask

    task automatic t_force200();
        set_mode(1'b0, 3'd2, 1'b1); run_lines("R10", K_DBL, 7, 100);
        set_mode(1'b1, 3'd0, 1'b1); run_lines("R10", K_DBL, 7, 100);
        set_mode(1'b0, 3'd0, 1'b0);
    endtask

    task automatic t_wrap();
        @(negedge clk) vtotal = 10'd6; vdiv2_en = 1'b0;
        set_mode(1'b0, 3'd0, 1'b0); run_lines("R3", K_NONE, 14, 6);
        set_mode(1'b0, 3'd2, 1'b0); run_lines("R3", K_34, 14, 6);
        @(negedge clk) vtotal = 10'd10; vdiv2_en = 1'b1;
        set_mode(1'b0, 3'd2, 1'b0); run_lines("R4", K_34, 13, 5);
        set_mode(1'b0, 3'd1, 1'b0); run_lines("R4", K_DBL, 11, 5);
        @(negedge clk) vtotal = 10'd100; vdiv2_en = 1'b0;
    endtask

    task automatic t_frame_priority();
        set_mode(1'b0, 3'd1, 1'b0);
        run_lines("R2", K_DBL, 5, 100);
        @(negedge clk) begin frame_start = 1'b1; line_tick = 1'b1; end
        @(negedge clk) begin frame_start = 1'b0; line_tick = 1'b0; end
        check("R2", 0, 0, 1'b0);
        tick();
        check("R2", 1, 0, 1'b1);
    endtask

    task automatic t_hold();
        set_mode(1'b0, 3'd2, 1'b0);
        run_lines("R11", K_34, 3, 100);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) check("R11", 3, 2, 1'b1);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_normal();
        t_gfx_patterns();
        t_text_patterns();
        t_cross_codes();
        t_force200();
        t_wrap();
        t_frame_priority();
        t_hold();
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule